// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM

This block is a synchronous static memory whose data bus can switch between reads and writes on every clock with no idle cycles in between. Address, chip enables, read/write control and byte-lane enables are captured at the rising clock edge. Write data is late: it arrives on the write-data bus one edge after its address in flow-through mode, and two edges after it in pipelined mode. The write data lines up with the slot that a read would use on the output bus. Because of this alignment, a read can follow a write, or a write a read, with nothing inserted.

A static mode pin selects the timing. In pipelined mode, read data passes through an output register. In flow-through mode, the array output goes straight to the pins. After a start command, a burst-continue input runs the same operation through four beats. The low two address bits step either by incrementing or by XOR with the beat number. Each 9-bit lane has its own write enable. An asynchronous output enable and an asynchronous sleep input can gate the data outputs at any moment. A read that hits a write whose data is just arriving receives that data, merged lane by lane, rather than the stale array word.

Top module: `nbt_sram`

## Requirements
- R1: A new operation starts at a rising edge only when ce1_n=0, ce2=1 and ce3_n=0 and adv=0. we_n=1 means read and we_n=0 means write. Any other combination with adv=0 is a deselect: it produces no output and writes nothing.
- R2: In pipelined mode (pipe_mode=1), read data for an address taken at edge n is on dq_out, with dq_oe=1, between edges n+1 and n+2.
- R3: In flow-through mode (pipe_mode=0), read data for an address taken at edge n is on dq_out, with dq_oe=1, between edges n and n+1.
- R4: Write data for an address taken at edge n is sampled from wdata at edge n+2 in pipelined mode and at edge n+1 in flow-through mode.
- R5: Reads and writes may alternate on consecutive edges. Every read returns the data of all writes whose data was sampled at or before its output slot.
- R6: Lane i occupies bits 9*i+8 to 9*i. A write updates lane i only when bw_n[i]=0, and bw_n is sampled with the address. The other lanes keep their contents.
- R7: With adv=1, the previous operation continues on the next beat and the chip enables are ignored. The low two address bits are (start+beat) mod 4 when burst_ilv=0 and start XOR beat when burst_ilv=1. The upper bits stay fixed. adv=1 after a deselect is a deselect.
- R8: oe_n=1 forces dq_oe to 0 at once, without waiting for a clock edge.
- R9: While sleep=1, the edge starts no operation (adv included) and dq_oe is 0. The array keeps its contents, and writes already issued still complete.
- R10: In pipelined mode, a read issued the edge after a write to the same address returns the arriving write data on enabled lanes and the array data on the other lanes.
- R11: After reset, dq_oe is 0 and no burst is in progress. Reset does not clear the array.
- R12: dq_out is all zeros whenever dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| pipe_mode | input | 1 | 1 selects pipelined timing, 0 selects flow-through (static) |
| burst_ilv | input | 1 | 1 selects interleaved burst order, 0 selects linear (static) |
| sleep | input | 1 | Asynchronous power-down request |
| oe_n | input | 1 | Asynchronous active-low output enable |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv | input | 1 | Continue the current burst |
| we_n | input | 1 | 0 = write, 1 = read |
| bw_n | input | 2 | Per-lane write enables, active low |
| addr | input | 6 | Word address |
| wdata | input | 18 | Late write data |
| dq_out | output | 18 | Read data, zero when not driven |
| dq_oe | output | 1 | High while read data is driven |

## Verification
The bench goes after a read issued one edge after a write to the same address with only some lanes enabled. A design without forwarding returns the old word there, and one that forwards the whole word corrupts the untouched lane. It also checks bursts that wrap in both orders, where an incrementing sequence that carries into the upper address bits, or a mixed-up choice of order, reads the wrong word. Further checks cover a write issued under sleep or with one chip enable wrong, which a careless decoder would commit, and an output enable dropped in mid-cycle, which a registered enable would only honour at the next edge.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low two address bits of a burst beat: XOR order or wrapping increment.
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input logic       ilv);
    logic [1:0] sum;
    sum = start + beat;
    return ilv ? (start ^ beat) : sum;
  endfunction

endpackage

// File: rtl/nbt_cmd_ctrl.sv
module nbt_cmd_ctrl
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              burst_ilv,
  input  logic              adv,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               iss_op,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [LANES-1:0]  iss_be
);

  op_e               last_op;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic [1:0]        beat_nx;
  logic              ce_ok;
  logic              start_new;
  logic              advance;

  always_comb begin
    ce_ok     = !ce1_n && ce2 && !ce3_n;
    beat_nx   = beat_q + 2'd1;
    iss_op    = OP_IDLE;
    iss_addr  = addr;
    start_new = 1'b0;
    advance   = 1'b0;
    if (!sleep) begin
      if (adv) begin
        iss_op   = last_op;
        iss_addr = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], beat_nx, burst_ilv)};
        advance  = (last_op != OP_IDLE);
      end else if (ce_ok) begin
        iss_op    = we_n ? OP_READ : OP_WRITE;
        start_new = 1'b1;
      end
    end
    iss_be = (iss_op == OP_WRITE) ? ~bw_n : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op <= OP_IDLE;
      base_q  <= '0;
      beat_q  <= '0;
    end else begin
      last_op <= iss_op;
      if (start_new) begin
        base_q <= addr;
        beat_q <= '0;
      end else if (advance) begin
        beat_q <= beat_nx;
      end
    end
  end

endmodule

// File: rtl/nbt_wr_pipe.sv
module nbt_wr_pipe
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  op_e               iss_op,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [LANES-1:0]  iss_be,
  output logic              s1_rd,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [LANES-1:0]  commit_be,
  output logic              fwd_hit,
  output logic [LANES-1:0]  fwd_be
);

  op_e               s1_op, s2_op;
  logic [LANES-1:0]  s1_be, s2_be;
  logic [ADDR_W-1:0] s2_addr;
  logic              s2_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op <= OP_IDLE;
      s2_op <= OP_IDLE;
    end else begin
      s1_op <= iss_op;
      s2_op <= s1_op;
    end
  end

  always_ff @(posedge clk) begin
    s1_addr <= iss_addr;
    s1_be   <= iss_be;
    s2_addr <= s1_addr;
    s2_be   <= s1_be;
  end

  assign s1_rd = (s1_op == OP_READ);
  assign s1_wr = (s1_op == OP_WRITE);
  assign s2_wr = (s2_op == OP_WRITE);

  // Late write: the stage holding the address meets its data on wdata.
  assign commit_en   = pipe_mode ? s2_wr   : s1_wr;
  assign commit_addr = pipe_mode ? s2_addr : s1_addr;
  assign commit_be   = pipe_mode ? s2_be   : s1_be;

  // Only pipelined mode has a write still in flight while a read samples.
  assign fwd_hit = pipe_mode && s1_rd && s2_wr && (s2_addr == s1_addr);
  assign fwd_be  = s2_be;

endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end
    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/nbt_rd_out.sv
module nbt_rd_out #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic              s1_rd,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              fwd_hit,
  input  logic [LANES-1:0]  fwd_be,
  input  logic [DATA_W-1:0] wdata,
  output logic              out_vld,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] src_data;
  logic              src_vld;

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (fwd_hit && fwd_be[g]) ?
      wdata[g*LANE_W +: LANE_W] : arr_data[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= s1_rd;
  end

  always_ff @(posedge clk) out_q <= merged;

  assign src_vld  = pipe_mode ? out_vld : s1_rd;
  assign src_data = pipe_mode ? out_q   : arr_data;
  assign dq_oe    = src_vld && !oe_n && !sleep;
  assign dq_out   = dq_oe ? src_data : '0;

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              burst_ilv,
  input  logic              sleep,
  input  logic              oe_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  op_e               iss_op;
  logic [ADDR_W-1:0] iss_addr;
  logic [LANES-1:0]  iss_be;
  logic              s1_rd, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [LANES-1:0]  commit_be;
  logic              fwd_hit;
  logic [LANES-1:0]  fwd_be;
  logic [DATA_W-1:0] arr_data;
  logic              out_vld;

  nbt_cmd_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .burst_ilv(burst_ilv), .adv(adv),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .bw_n(bw_n),
    .addr(addr), .iss_op(iss_op), .iss_addr(iss_addr), .iss_be(iss_be)
  );

  nbt_wr_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .iss_op(iss_op),
    .iss_addr(iss_addr), .iss_be(iss_be), .s1_rd(s1_rd), .s1_wr(s1_wr),
    .s1_addr(s1_addr), .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_be(commit_be), .fwd_hit(fwd_hit), .fwd_be(fwd_be)
  );

  nbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .wr_en(commit_en), .wr_addr(commit_addr), .wr_be(commit_be),
    .wr_data(wdata), .rd_addr(s1_addr), .rd_data(arr_data)
  );

  nbt_rd_out #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe_n(oe_n), .sleep(sleep),
    .s1_rd(s1_rd), .arr_data(arr_data), .fwd_hit(fwd_hit), .fwd_be(fwd_be),
    .wdata(wdata), .out_vld(out_vld), .dq_out(dq_out), .dq_oe(dq_oe)
  );

endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              sleep,
  input logic              oe_n,
  input logic              adv,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              s1_vld,
  input logic              s1_rd,
  input logic              out_vld,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out
);

  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adv && !(!ce1_n && ce2 && !ce3_n)) |=> !s1_vld);

  a_r2_pipe_out_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && s1_rd) |=> out_vld);

  a_r3_flow_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && s1_rd && !oe_n && !sleep) |-> dq_oe);

  a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);

  a_r9_sleep_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !s1_vld);

  a_r12_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

endmodule

bind nbt_sram nbt_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sleep(sleep), .oe_n(oe_n),
  .adv(adv), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .s1_vld(s1_rd | s1_wr),
  .s1_rd(s1_rd), .out_vld(out_vld), .dq_oe(dq_oe), .dq_out(dq_out)
);

// File: tb/nbt_sram_tb_top.sv
module nbt_sram_tb_top;

  localparam int AW = 6;
  localparam int NL = 2;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_mode = 1'b1, burst_ilv = 1'b0, sleep = 1'b0, oe_n = 1'b0;
  logic ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1, adv = 1'b0, we_n = 1'b1;
  logic [NL-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  always #4 clk = ~clk;

  nbt_sram dut_i (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
    .sleep(sleep), .oe_n(oe_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adv(adv), .we_n(we_n), .bw_n(bw_n), .addr(addr), .wdata(wdata),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int nvec = 0, nfail = 0;
  bit done = 0;

  // Reference model state: 0 idle, 1 read, 2 write.
  logic [DW-1:0] mem_m [1<<AW];
  int            h_op [3];
  logic [AW-1:0] h_addr [3];
  logic [NL-1:0] h_be [3];
  int            b_last;
  logic [AW-1:0] b_base;
  int            b_beat;
  bit            exp_vld;
  logic [DW-1:0] exp_data;
  string         exp_tag, dir_tag;

  function automatic logic [AW-1:0] f_burst(input logic [AW-1:0] base, input int k, input bit ilv);
    int lo;
    lo = ilv ? (int'(base[1:0]) ^ k) : ((int'(base[1:0]) + k) % 4);
    return (base & ~AW'(3)) | AW'(lo);
  endfunction

  function automatic logic [DW-1:0] f_merge(input logic [DW-1:0] old_w, input logic [DW-1:0] new_w,
                                           input logic [NL-1:0] be);
    logic [DW-1:0] r;
    r = old_w;
    for (int l = 0; l < NL; l++) if (be[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
    return r;
  endfunction

  task automatic chk(input bit e_oe, input logic [DW-1:0] e, input string tag);
    nvec++;
    if (dq_oe !== e_oe || dq_out !== e) begin
      nfail++;
      $display("FAIL %s: dq_oe=%0b dq_out=%h expected dq_oe=%0b dq_out=%h", tag, dq_oe, dq_out, e_oe, e);
    end
  endtask

  task automatic check_out();
    bit e_oe;
    string t;
    e_oe = exp_vld && !oe_n && !sleep;
    t = (dir_tag != "") ? dir_tag : (oe_n ? "R8" : (sleep ? "R9" : exp_tag));
    chk(e_oe, e_oe ? exp_data : '0, t);
  endtask

  task automatic clear_model();
    for (int i = 0; i < 3; i++) h_op[i] = 0;
    b_last = 0; b_beat = 0; b_base = '0;
    exp_vld = 0; exp_tag = "R1";
  endtask

  // One clock: check the current slot, apply inputs, advance the model.
  task automatic step(input bit sl, input bit oe, input bit c1, input bit c2, input bit c3,
                      input bit ad, input bit we, input logic [NL-1:0] bw, input logic [AW-1:0] a);
    int op, lat, ri;
    logic [AW-1:0] ea;
    bit hit;
    check_out();
    sleep = sl; oe_n = oe; ce1_n = c1; ce2 = c2; ce3_n = c3; adv = ad; we_n = we;
    bw_n = bw; addr = a; wdata = DW'($urandom);
    op = 0; ea = a;
    if (!sl) begin
      if (ad) begin
        op = b_last;
        if (op != 0) begin b_beat = (b_beat + 1) % 4; ea = f_burst(b_base, b_beat, burst_ilv); end
      end else if (!c1 && c2 && !c3) begin
        op = we ? 1 : 2; b_base = a; b_beat = 0;
      end
    end
    b_last = op;
    h_op[2] = h_op[1]; h_addr[2] = h_addr[1]; h_be[2] = h_be[1];
    h_op[1] = h_op[0]; h_addr[1] = h_addr[0]; h_be[1] = h_be[0];
    h_op[0] = op; h_addr[0] = ea; h_be[0] = (op == 2) ? ~bw : '0;
    lat = pipe_mode ? 2 : 1;
    ri  = pipe_mode ? 1 : 0;
    hit = 0;
    if (h_op[lat] == 2) begin
      mem_m[h_addr[lat]] = f_merge(mem_m[h_addr[lat]], wdata, h_be[lat]);
      hit = (h_op[ri] == 1) && (h_addr[ri] == h_addr[lat]);
    end
    exp_vld = (h_op[ri] == 1);
    exp_data = mem_m[h_addr[ri]];
    exp_tag = !exp_vld ? "R1" : (hit ? "R10" : (pipe_mode ? "R2" : "R3"));
    @(negedge clk);
  endtask

  task automatic cmd(input bit we, input logic [NL-1:0] bw, input logic [AW-1:0] a);
    step(0, 0, 0, 1, 0, 0, we, bw, a);
  endtask
  task automatic burst_beat(input bit we);
    step(0, 0, 1, 0, 1, 1, we, 2'b00, '0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, 1, 0, 1, 2'b11, '0);
  endtask

  task automatic do_reset(input bit pm, input bit ilv);
    idle(3);
    rst_n = 1'b0; pipe_mode = pm; burst_ilv = ilv;
    repeat (2) @(negedge clk);
    chk(1'b0, '0, "R11");  // outputs quiet under reset
    rst_n = 1'b1;
    clear_model();
    adv = 1'b1; ce1_n = 1'b1;
    // R11: adv right after reset continues nothing
    step(0, 0, 1, 0, 1, 1, 1, 2'b11, '0);
    step(0, 0, 1, 0, 1, 0, 1, 2'b11, '0);
    dir_tag = "R11"; check_out(); dir_tag = "";
  endtask

  initial begin
    begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
        nfail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd91357));
    for (int i = 0; i < (1<<AW); i++) mem_m[i] = '0;
    clear_model();
    dir_tag = "";
    repeat (3) @(negedge clk);
    chk(1'b0, '0, "R11");
    rst_n = 1'b1;
    @(negedge clk);

    // Fill the array so every word is known to the model.
    for (int i = 0; i < (1<<AW); i++) cmd(0, 2'b00, AW'(i));
    idle(3);

    // R10: pipelined read right behind a write to the same word, partial lanes.
    dir_tag = "R10";
    cmd(0, 2'b00, 6'd5); cmd(1, 2'b11, 6'd5);
    cmd(0, 2'b10, 6'd5); cmd(1, 2'b11, 6'd5);
    cmd(0, 2'b01, 6'd5); cmd(1, 2'b11, 6'd5); cmd(1, 2'b11, 6'd5);
    idle(3);
    // R5: alternating read/write on consecutive edges to different words.
    dir_tag = "R5";
    for (int i = 0; i < 12; i++) cmd(i % 2 == 0, 2'b00, AW'(10 + i % 3));
    idle(3);

    // Flow-through: R4 single late write, R6 lane masks.
    dir_tag = "";
    do_reset(0, 0);
    dir_tag = "R4";
    cmd(0, 2'b00, 6'd9); cmd(1, 2'b11, 6'd9); cmd(0, 2'b00, 6'd9); cmd(1, 2'b11, 6'd9);
    idle(2);
    dir_tag = "R6";
    cmd(0, 2'b10, 6'd20); idle(1); cmd(1, 2'b11, 6'd20);
    cmd(0, 2'b01, 6'd20); idle(1); cmd(1, 2'b11, 6'd20);
    cmd(0, 2'b11, 6'd20); idle(1); cmd(1, 2'b11, 6'd20);
    idle(2);
    // R8: output enable dropped within the output cycle.
    dir_tag = "R8";
    cmd(1, 2'b11, 6'd9);
    oe_n = 1'b1; #1; chk(1'b0, '0, "R8");
    oe_n = 1'b0; #1;
    idle(2);
    // R9: commands under sleep are ignored; R1: one enable wrong means no write.
    dir_tag = "R9";
    step(1, 0, 0, 1, 0, 0, 0, 2'b00, 6'd3); step(1, 0, 0, 1, 0, 1, 0, 2'b00, 6'd3);
    idle(2); cmd(1, 2'b11, 6'd3); idle(2);
    dir_tag = "R1";
    step(0, 0, 0, 0, 0, 0, 0, 2'b00, 6'd4); step(0, 0, 0, 1, 1, 0, 0, 2'b00, 6'd4);
    step(0, 0, 1, 1, 0, 0, 0, 2'b00, 6'd4);
    idle(2); cmd(1, 2'b11, 6'd4); idle(2);

    // R7: four-beat bursts starting mid-quad, both orders, both modes.
    for (int m = 0; m < 4; m++) begin
      dir_tag = "";
      do_reset(m[1], m[0]);
      dir_tag = "R7";
      cmd(0, 2'b00, 6'd38); burst_beat(0); burst_beat(0); burst_beat(0);
      cmd(1, 2'b11, 6'd38); burst_beat(1); burst_beat(1); burst_beat(1);
      cmd(1, 2'b11, 6'd39); burst_beat(1); burst_beat(1); burst_beat(1); burst_beat(1);
      idle(1); burst_beat(1);
      idle(3);
    end

    // Random traffic in every mode combination.
    dir_tag = "";
    for (int m = 0; m < 4; m++) begin
      do_reset(m[0], m[1]);
      for (int i = 0; i < 3000; i++) begin
        bit sl, oe, c1, c2, c3, ad, we;
        logic [NL-1:0] bw;
        logic [AW-1:0] a;
        sl = ($urandom % 32) == 0;
        oe = ($urandom % 16) == 0;
        if (($urandom % 8) != 0) begin c1 = 0; c2 = 1; c3 = 0; end
        else begin c1 = $urandom % 2; c2 = $urandom % 2; c3 = $urandom % 2; end
        ad = ($urandom % 4) == 0;
        we = $urandom % 2;
        bw = NL'($urandom);
        a  = ($urandom % 2) ? AW'($urandom % 8) : AW'($urandom);
        step(sl, oe, c1, c2, c3, ad, we, bw, a);
      end
    end
    idle(3);
    check_out();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule